// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits beside a page-programmed non-volatile array. It watches every bus write cycle and picks out multi-write unlock commands. Each step of a command is a fixed data byte written to a fixed command address. The block keeps the mode state for several functions: software write protection, the page-load window, chip erase, boot-block lockout and identification mode. For each write cycle, in the same cycle, it decides whether that write may reach the page buffer. It raises one-cycle requests for chip erase and for boot-block lockout. In identification mode it supplies fixed read data for a small set of addresses.

Every command starts with the same two-write prefix: AA to 5555, then 55 to 2AAA. The third write selects the command. A0 opens a page load. F0 leaves identification mode. 80 enters identification mode and also starts the six-write family. A six-write command repeats the prefix after the 80 and ends with a selector byte at 5555. The boot-lockout command adds a seventh write that names the block to lock. Array storage and erase timing belong to the downstream write engine.

Top module: `cmd_seq_decoder`

## Requirements
- R1: Command addresses match on the low 15 address bits only. While protection is on, a write is passed (`wr_permit` high) only inside a load window. The window is opened by AA@5555, 55@2AAA, A0@5555.
- R2: After `por_n`, protection is on, both lockouts are clear and identification mode is off.
- R3: The six-write sequence AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 turns protection off. After that, ordinary writes pass with no load window.
- R4: The A0 command turns protection on from any state and opens a load window.
- R5: A load window closes after LOAD_WIN cycles with no passed write. Each passed write restarts the count. The first passed write fixes the page (address bits 18:8), and writes to any other page are refused. No command is decoded while the window is open.
- R6: The six-write form ending in 10@5555 raises `erase_req` for one cycle, in the cycle after that write. It does nothing if either lockout is set.
- R7: Identification mode is entered by the third write 80@5555, or by the six-write form ending in 60@5555. It is left by the three-write form ending in F0@5555. The six-write forms ending in 20, 10 or 40 clear it.
- R8: In identification mode a read strobe overrides data. Address 0 reads DA and address 1 reads 46. Address 2 reads FF if the lower block (address bits 18:14 all zero) is locked, else FE. Address 7FFF2 reads FF if the upper block (bits 18:14 all one) is locked, else FE. Other addresses, and every address outside identification mode, have no override.
- R9: The six-write form ending in 40@5555 followed by 00 to address 0 locks the lower block. Followed instead by FF to address 7FFFF, it locks the upper block. `lock_req` pulses in the next cycle, with `lock_sel` 0 for lower and 1 for upper. A lock is cleared only by `por_n`.
- R10: A write into a locked block is never passed, whatever the protection or window state.
- R11: A write that is not the expected next step returns the decoder to idle. That write is judged as an ordinary data write.
- R12: `rst_n` clears identification mode, the sequence state and the load window. It keeps protection and lockouts.
- R13: Writes that advance a command sequence are consumed and never passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sync; clears all state |
| rst_n | input | 1 | Reset, active low, sync; keeps protection and lockouts |
| wr_stb | input | 1 | One write cycle in this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | One read cycle in this clock |
| rd_addr | input | ADDR_W | Read address |
| wr_permit | output | 1 | This write may go to the page buffer (combinational) |
| erase_req | output | 1 | Chip-erase request pulse |
| lock_req | output | 1 | Boot-lockout set pulse |
| lock_sel | output | 1 | Block of the last lockout: 0 lower, 1 upper |
| id_mode | output | 1 | Identification mode active |
| rd_ovr | output | 1 | Read data is overridden (combinational) |
| rd_ovr_data | output | 8 | Override data |

## Verification
A bad sequence state shows up on `wr_permit` at the very next write. A step is then either swallowed or passed, or a later command ends with a missing or extra pulse one cycle after its last write. A wrong protect bit, window count or page latch shows on the first ordinary write after it. A wrong lockout bit shows on the first write into that block, or on the status read in identification mode. The reference model is compared on every clock, so any of these is seen in the cycle it first reaches a port.

// File: rtl/cmd_seq_decoder.sv
`timescale 1ns/1ps
module cmd_seq_decoder #(
  parameter int ADDR_W   = 19,
  parameter int CMD_W    = 15,
  parameter int BLK_W    = 14,
  parameter int PAGE_W   = 8,
  parameter int LOAD_WIN = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_permit,
  output logic              erase_req,
  output logic              lock_req,
  output logic              lock_sel,
  output logic              id_mode,
  output logic              rd_ovr,
  output logic [7:0]        rd_ovr_data
);

  localparam int WIN_W = $clog2(LOAD_WIN + 1);
  localparam int TAG_W = ADDR_W - BLK_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam logic [CMD_W-1:0]  CA_ONE = CMD_W'(15'h5555);
  localparam logic [CMD_W-1:0]  CA_TWO = CMD_W'(15'h2AAA);
  localparam logic [ADDR_W-1:0] TOP    = '1;
  localparam logic [ADDR_W-1:0] STAT_HI = {{(ADDR_W-4){1'b1}}, 4'h2};

  typedef enum logic [2:0] {S_IDLE, S_P1, S_P2, S_X1, S_X2, S_X3, S_LK} st_t;

  st_t              st_q, st_d;
  logic             prot_q, id_q, pgv_q, erase_q, lreq_q, lsel_q;
  logic [1:0]       lock_q;
  logic [WIN_W-1:0] win_cnt;
  logic [PG_W-1:0]  pg_q;

  logic take, do_a0, do_id_on, do_id_off, do_unprot, do_erase, do_lock0, do_lock1;

  wire win_open = win_cnt != '0;
  wire at_one   = wr_addr[CMD_W-1:0] == CA_ONE;
  wire at_two   = wr_addr[CMD_W-1:0] == CA_TWO;
  wire hit_lock = (lock_q[0] && wr_addr[ADDR_W-1:BLK_W] == '0) ||
                  (lock_q[1] && wr_addr[ADDR_W-1:BLK_W] == {TAG_W{1'b1}});
  wire page_ok  = !pgv_q || wr_addr[ADDR_W-1:PAGE_W] == pg_q;

  always_comb begin
    st_d = st_q;
    take = 1'b0;
    do_a0 = 1'b0; do_id_on = 1'b0; do_id_off = 1'b0; do_unprot = 1'b0;
    do_erase = 1'b0; do_lock0 = 1'b0; do_lock1 = 1'b0;
    if (wr_stb && !win_open && rst_n && por_n) begin
      st_d = S_IDLE;
      case (st_q)
        S_IDLE: if (at_one && wr_data == 8'hAA) begin take = 1'b1; st_d = S_P1; end
        S_P1:   if (at_two && wr_data == 8'h55) begin take = 1'b1; st_d = S_P2; end
        S_P2: if (at_one) begin
          case (wr_data)
            8'hA0: begin take = 1'b1; do_a0 = 1'b1; end
            8'h80: begin take = 1'b1; do_id_on = 1'b1; st_d = S_X1; end
            8'hF0: begin take = 1'b1; do_id_off = 1'b1; end
            default: ;
          endcase
        end
        S_X1:   if (at_one && wr_data == 8'hAA) begin take = 1'b1; st_d = S_X2; end
        S_X2:   if (at_two && wr_data == 8'h55) begin take = 1'b1; st_d = S_X3; end
        S_X3: if (at_one) begin
          case (wr_data)
            8'h20: begin take = 1'b1; do_unprot = 1'b1; do_id_off = 1'b1; end
            8'h10: begin take = 1'b1; do_erase = 1'b1; do_id_off = 1'b1; end
            8'h60: begin take = 1'b1; do_id_on = 1'b1; end
            8'h40: begin take = 1'b1; do_id_off = 1'b1; st_d = S_LK; end
            default: ;
          endcase
        end
        S_LK: begin
          if (wr_data == 8'h00 && wr_addr == '0) begin take = 1'b1; do_lock0 = 1'b1; end
          else if (wr_data == 8'hFF && wr_addr == TOP) begin take = 1'b1; do_lock1 = 1'b1; end
        end
        default: ;
      endcase
    end
  end

  assign wr_permit = wr_stb && !take && !hit_lock && (win_open ? page_ok : !prot_q);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      prot_q <= 1'b1;
      lock_q <= '0;
      lsel_q <= 1'b0;
    end else begin
      if (do_a0)          prot_q <= 1'b1;
      else if (do_unprot) prot_q <= 1'b0;
      if (do_lock0) lock_q[0] <= 1'b1;
      if (do_lock1) lock_q[1] <= 1'b1;
      if (do_lock0 || do_lock1) lsel_q <= do_lock1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      st_q    <= S_IDLE;
      id_q    <= 1'b0;
      win_cnt <= '0;
      pgv_q   <= 1'b0;
      erase_q <= 1'b0;
      lreq_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      erase_q <= do_erase && lock_q == 2'b00;
      lreq_q  <= do_lock0 || do_lock1;
      if (do_id_on)       id_q <= 1'b1;
      else if (do_id_off) id_q <= 1'b0;
      if (do_a0) begin
        win_cnt <= WIN_W'(LOAD_WIN);
        pgv_q   <= 1'b0;
      end else if (win_open) begin
        if (wr_permit) begin
          win_cnt <= WIN_W'(LOAD_WIN);
          if (!pgv_q) begin
            pgv_q <= 1'b1;
            pg_q  <= wr_addr[ADDR_W-1:PAGE_W];
          end
        end else begin
          win_cnt <= win_cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_ovr      = 1'b0;
    rd_ovr_data = 8'h00;
    if (rd_stb && id_q) begin
      if (rd_addr == '0)                      begin rd_ovr = 1'b1; rd_ovr_data = 8'hDA; end
      else if (rd_addr == ADDR_W'(1))         begin rd_ovr = 1'b1; rd_ovr_data = 8'h46; end
      else if (rd_addr == ADDR_W'(2))         begin rd_ovr = 1'b1; rd_ovr_data = lock_q[0] ? 8'hFF : 8'hFE; end
      else if (rd_addr == STAT_HI)            begin rd_ovr = 1'b1; rd_ovr_data = lock_q[1] ? 8'hFF : 8'hFE; end
    end
  end

  assign erase_req = erase_q;
  assign lock_req  = lreq_q;
  assign lock_sel  = lsel_q;
  assign id_mode   = id_q;

  assert_erase_refused_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    erase_req |-> lock_q == 2'b00);
  assert_lock_sticky_lo_R9: assert property (@(posedge clk) disable iff (!por_n)
    lock_q[0] |=> lock_q[0]);
  assert_lock_sticky_hi_R9: assert property (@(posedge clk) disable iff (!por_n)
    lock_q[1] |=> lock_q[1]);
  assert_lock_req_sets_R9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    lock_req |-> lock_q[lock_sel]);
  assert_pulses_apart_R9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !(erase_req && lock_req));
  assert_protected_needs_window_R1: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_permit && prot_q) |-> win_open);
  assert_window_bounded_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    win_cnt <= WIN_W'(LOAD_WIN));
  assert_override_in_id_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    rd_ovr |-> id_mode);

endmodule

// File: tb/test_cmd_seq_decoder.sv
`timescale 1ns/1ps
module test_cmd_seq_decoder;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n = 1'b0, rst_n = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [18:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_permit, erase_req, lock_req, lock_sel, id_mode, rd_ovr;
  logic [7:0] rd_ovr_data;

  cmd_seq_decoder i_cmd_seq_decoder (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_addr(rd_addr), .wr_permit(wr_permit),
    .erase_req(erase_req), .lock_req(lock_req), .lock_sel(lock_sel), .id_mode(id_mode),
    .rd_ovr(rd_ovr), .rd_ovr_data(rd_ovr_data));

  int checks = 0, errors = 0;
  string req = "R2";
  bit cmp_on = 0;

  bit m_prot, m_lock0, m_lock1, m_id, m_erase, m_lreq, m_lsel, m_pgv;
  int m_win;
  logic [10:0] m_pg;
  logic [7:0] q[$];

  function automatic bit step_ok(int n, logic [18:0] a, logic [7:0] d);
    logic [14:0] lo = a[14:0];
    case (n)
      0, 3: return lo == 15'h5555 && d == 8'hAA && (n == 0 || q[2] == 8'h80);
      1, 4: return lo == 15'h2AAA && d == 8'h55;
      2: return lo == 15'h5555 && (d == 8'hA0 || d == 8'h80 || d == 8'hF0);
      5: return lo == 15'h5555 && (d == 8'h20 || d == 8'h10 || d == 8'h60 || d == 8'h40);
      6: return q[5] == 8'h40 && ((d == 8'h00 && a == 19'h0) || (d == 8'hFF && a == 19'h7FFFF));
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string nm, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic model_reset(bit por);
    q.delete(); m_id = 0; m_win = 0; m_pgv = 0; m_erase = 0; m_lreq = 0;
    if (por) begin m_prot = 1; m_lock0 = 0; m_lock1 = 0; m_lsel = 0; end
  endtask

  task automatic cyc(bit w, logic [18:0] a, logic [7:0] d, bit r, logic [18:0] ra);
    bit open, lockhit, take, ep, eo;
    logic [7:0] ed;
    int n, nwin;
    @(negedge clk);
    wr_stb = w; wr_addr = a; wr_data = d; rd_stb = r; rd_addr = ra;
    #1;
    open = m_win > 0;
    lockhit = (m_lock0 && a[18:14] == 5'h00) || (m_lock1 && a[18:14] == 5'h1F);
    n = q.size();
    take = w && !open && step_ok(n, a, d);
    ep = w && !take && !lockhit && (open ? (!m_pgv || a[18:8] == m_pg) : !m_prot);
    eo = 0; ed = 8'h00;
    if (r && m_id) begin
      if (ra == 19'h0) begin eo = 1; ed = 8'hDA; end
      else if (ra == 19'h1) begin eo = 1; ed = 8'h46; end
      else if (ra == 19'h2) begin eo = 1; ed = m_lock0 ? 8'hFF : 8'hFE; end
      else if (ra == 19'h7FFF2) begin eo = 1; ed = m_lock1 ? 8'hFF : 8'hFE; end
    end
    if (cmp_on) begin
      chk("wr_permit", {7'b0, wr_permit}, {7'b0, ep});
      chk("rd_ovr", {7'b0, rd_ovr}, {7'b0, eo});
      if (eo) chk("rd_ovr_data", rd_ovr_data, ed);
      chk("id_mode", {7'b0, id_mode}, {7'b0, m_id});
      chk("erase_req", {7'b0, erase_req}, {7'b0, m_erase});
      chk("lock_req", {7'b0, lock_req}, {7'b0, m_lreq});
      chk("lock_sel", {7'b0, lock_sel}, {7'b0, m_lsel});
    end
    m_erase = 0; m_lreq = 0; nwin = m_win;
    if (open) begin
      if (ep) begin
        nwin = LW;
        if (!m_pgv) begin m_pgv = 1; m_pg = a[18:8]; end
      end else nwin = m_win - 1;
    end
    if (w && !open) begin
      if (take) begin
        q.push_back(d);
        if (n == 2) begin
          if (d == 8'hA0) begin m_prot = 1; nwin = LW; m_pgv = 0; q.delete(); end
          else if (d == 8'hF0) begin m_id = 0; q.delete(); end
          else m_id = 1;
        end else if (n == 5) begin
          m_id = (d == 8'h60);
          if (d == 8'h20) m_prot = 0;
          if (d == 8'h10) m_erase = !m_lock0 && !m_lock1;
          if (d != 8'h40) q.delete();
        end else if (n == 6) begin
          if (d == 8'h00) m_lock0 = 1; else m_lock1 = 1;
          m_lreq = 1; m_lsel = (d == 8'hFF); q.delete();
        end
      end else q.delete();
    end
    m_win = nwin;
  endtask

  task automatic wr(logic [18:0] a, logic [7:0] d); cyc(1, a, d, 0, 19'h0); endtask
  task automatic rd(logic [18:0] a); cyc(0, 19'h0, 8'h00, 1, a); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 19'h0, 8'h00, 0, 19'h0); endtask
  task automatic pfx(); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); endtask
  task automatic six(logic [7:0] sel);
    pfx(); wr(19'h05555, 8'h80); pfx(); wr(19'h05555, sel);
  endtask

  task automatic do_reset(bit por);
    @(negedge clk);
    wr_stb = 0; rd_stb = 0; rst_n = 0;
    if (por) por_n = 0;
    @(negedge clk);
    rst_n = 1; por_n = 1;
    model_reset(por);
    cmp_on = 1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req = "R2"; do_reset(1); idle(2);
    req = "R1"; wr(19'h00100, 8'h11);
    pfx(); wr(19'h05555, 8'hA0);
    wr(19'h00300, 8'h01); wr(19'h00305, 8'h02);
    req = "R5"; wr(19'h00400, 8'h03); idle(LW + 3); wr(19'h00300, 8'h04);
    req = "R1"; wr(19'h3D555, 8'hAA); wr(19'h42AAA, 8'h55); wr(19'h55555, 8'hA0);
    wr(19'h00310, 8'h05); idle(LW + 2);
    req = "R7"; pfx(); wr(19'h05555, 8'h80);
    req = "R8"; rd(19'h0); rd(19'h1); rd(19'h2); rd(19'h7FFF2); rd(19'h5);
    req = "R7"; pfx(); wr(19'h05555, 8'hF0);
    req = "R8"; rd(19'h0);
    req = "R3"; six(8'h20); wr(19'h20000, 8'h09);
    req = "R12"; do_reset(0); wr(19'h20001, 8'h01);
    req = "R6"; six(8'h10); idle(2);
    req = "R11"; wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h12); wr(19'h02AAA, 8'h55);
    req = "R13"; pfx(); wr(19'h05555, 8'h33);
    req = "R9"; six(8'h40); wr(19'h00000, 8'h00); idle(2);
    req = "R10"; wr(19'h00100, 8'h03); wr(19'h04000, 8'h03);
    req = "R8"; six(8'h60); rd(19'h2); rd(19'h7FFF2); pfx(); wr(19'h05555, 8'hF0);
    req = "R6"; six(8'h10); idle(2);
    req = "R9"; six(8'h40); wr(19'h7FFFF, 8'hFF); idle(2);
    req = "R10"; wr(19'h7FFF0, 8'h01); wr(19'h40000, 8'h01);
    req = "R4"; pfx(); wr(19'h05555, 8'hA0); wr(19'h7FF00, 8'h01); idle(LW + 2); wr(19'h20000, 8'h01);
    req = "R12"; pfx(); wr(19'h05555, 8'h80); do_reset(0); rd(19'h0); wr(19'h20000, 8'h01);
    req = "R2"; do_reset(1); rd(19'h2); wr(19'h00100, 8'h01);
    req = "R11";
    for (int i = 0; i < 4000; i++) begin
      logic [18:0] al[8] = '{19'h05555, 19'h02AAA, 19'h00000, 19'h7FFFF,
                             19'h00100, 19'h7FFF0, 19'h12345, 19'h1D555};
      logic [7:0]  dl[12] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'hF0, 8'h20,
                              8'h10, 8'h60, 8'h40, 8'h00, 8'hFF, 8'h37};
      logic [18:0] rl[5] = '{19'h0, 19'h1, 19'h2, 19'h7FFF2, 19'h3};
      int k = $urandom_range(0, 99);
      if (k < 2) do_reset(0);
      else if (k < 25) cyc(0, 19'h0, 8'h00, 1, rl[$urandom_range(0, 4)]);
      else if (k < 40) idle(1);
      else cyc(1, al[$urandom_range(0, 7)], dl[$urandom_range(0, 11)], 0, 19'h0);
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule